// File: doc/BRIEF.md
# Invalidation completion interrupt controller

This block owns the interrupt control word for invalidation-completion events together with the completion-status flag that feeds it. When an invalidation wait descriptor that requests an interrupt finishes, the status flag is set. If that flag was clear beforehand, a pending bit is raised. While the pending bit is set, the interrupt is not masked and no transient hold is asserted, the block raises a message-signalled interrupt request. The request carries the event data and event address supplied by the companion registers.

Software reaches the control word and the status word through a simple 32-bit register port. Reads are combinational and writes take effect on the clock edge. A pending event is dropped without a message if software clears the status flag before the request has been raised. A strap tells the block whether queued invalidation exists. Without it, the block reads as zero and ignores all stimulus.

Top module: `inv_irq_ctrl`

## Requirements
- R1: After reset the control word reads 0x80000000 (mask set, nothing pending), the status word reads 0 and `msg_valid` is low.
- R2: In the control word, bit 31 is the software read/write mask and bit 30 is the read-only pending flag. Bits 29:0 read as zero. Writes to bits 30:0 have no effect.
- R3: `msg_valid` never rises while the mask holds 1.
- R4: A `cmpl_valid` pulse with `cmpl_irq` high sets status bit 0. If bit 0 was clear, the pulse also sets the pending flag. A pulse with `cmpl_irq` low changes nothing.
- R5: A qualified completion that arrives while status bit 0 is already set does not set the pending flag again.
- R6: With the flag pending, the mask clear and `hold` low, `msg_valid` rises one cycle later. `msg_data` and `msg_addr` carry the `evt_data` and `evt_addr` values of that cycle. The pending flag clears on the cycle the request is accepted (`msg_valid` and `msg_ready` both high).
- R7: While `hold` is high, no request is raised and the pending flag stays set.
- R8: Once raised, `msg_valid`, `msg_data` and `msg_addr` stay unchanged until acceptance. At most one request is outstanding.
- R9: Writing 1 to status bit 0 clears it, clears the pending flag, and prevents a message for that event if none has been raised yet. Writing 0 has no effect.
- R10: If a qualified completion and a status clear fall in the same cycle, status bit 0 and the pending flag both end up set.
- R11: With `qi_supported` low, both words read as zero, register writes are ignored and completions are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| qi_supported | input | 1 | Strap: queued invalidation present |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register word select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| cmpl_valid | input | 1 | Wait descriptor completion pulse |
| cmpl_irq | input | 1 | Completion asks for an interrupt |
| hold | input | 1 | Transient back-pressure on message issue |
| evt_data | input | MSG_DW | Event data from companion register |
| evt_addr | input | MSG_AW | Event address from companion register |
| msg_valid | output | 1 | Message request valid |
| msg_ready | input | 1 | Message request accepted |
| msg_data | output | MSG_DW | Message data |
| msg_addr | output | MSG_AW | Message address |

## Verification
The bench builds the block with a 16-bit message data field, a 40-bit address field, a 3-bit register select, and the control and status words placed at offsets 2 and 5. This shows that no decode or width depends on the default layout. The narrow, odd widths make captured-versus-live data mismatches easy to spot when `evt_data` changes during a stalled request. The non-adjacent offsets also show that writes to one word cannot leak into the other.

// File: rtl/inv_irq_pkg.sv
package inv_irq_pkg;
  localparam int MASK_BIT = 31;
  localparam int PEND_BIT = 30;
  localparam int STAT_BIT = 0;

  // next value of the completion-status flag; a completion beats a clear
  function automatic logic f_stat_next(input logic stat_q, input logic evt, input logic clr);
    return evt | (stat_q & ~clr);
  endfunction

  // a new interrupt condition: flag goes (or stays via same-cycle clear) from clear to set
  function automatic logic f_new_cond(input logic stat_q, input logic evt, input logic clr);
    return evt & (~stat_q | clr);
  endfunction
endpackage

// File: rtl/inv_status_flag.sv
module inv_status_flag
  import inv_irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic stat_q,
  output logic new_cond,
  output logic sw_drop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= f_stat_next(stat_q, evt, clr);
  end

  assign new_cond = f_new_cond(stat_q, evt, clr);
  assign sw_drop  = clr & ~evt;

  // R5: flag already set and no clear -> completion raises no new condition
  p_no_repeat_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && evt && !clr) |-> !new_cond);
  // R10: completion and clear together leave the flag set
  p_race_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && clr) |=> stat_q);
endmodule

// File: rtl/inv_pend_ctl.sv
module inv_pend_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ctrl_we,
  input  logic mask_wbit,
  input  logic new_cond,
  input  logic sw_drop,
  input  logic accept,
  input  logic hold,
  input  logic busy,
  output logic mask_q,
  output logic pend_q,
  output logic issue
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      if (ctrl_we) mask_q <= mask_wbit;
      if (new_cond)                pend_q <= 1'b1;
      else if (accept || sw_drop)  pend_q <= 1'b0;
    end
  end

  assign issue = pend_q & ~mask_q & ~hold & ~busy & ~sw_drop;

  // R6: acceptance without a fresh condition empties the pending flag
  p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !new_cond) |=> !pend_q);
  // R7: hold keeps the pending flag set
  p_hold_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && hold && !accept && !sw_drop) |=> pend_q);
  // R9: software clear without completion drops the pending event
  p_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_drop && !accept) |=> !pend_q);
endmodule

// File: rtl/inv_msg_port.sv
module inv_msg_port #(
  parameter int DW = 32,
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] evt_data,
  input  logic [AW-1:0] evt_addr,
  input  logic          msg_ready,
  output logic          msg_valid,
  output logic [DW-1:0] msg_data,
  output logic [AW-1:0] msg_addr,
  output logic          accept
);
  assign accept = msg_valid & msg_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_valid <= 1'b0;
      msg_data  <= '0;
      msg_addr  <= '0;
    end else if (issue) begin
      msg_valid <= 1'b1;
      msg_data  <= evt_data;
      msg_addr  <= evt_addr;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end

  // R8: stalled request holds its payload
  p_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_data) && $stable(msg_addr)));
  // R8: never a second issue while one is outstanding
  p_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> !issue);
endmodule

// File: rtl/inv_irq_ctrl.sv
module inv_irq_ctrl
  import inv_irq_pkg::*;
#(
  parameter int MSG_DW   = 32,
  parameter int MSG_AW   = 64,
  parameter int REG_AW   = 4,
  parameter int CTRL_OFF = 0,
  parameter int STAT_OFF = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              qi_supported,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              cmpl_valid,
  input  logic              cmpl_irq,
  input  logic              hold,
  input  logic [MSG_DW-1:0] evt_data,
  input  logic [MSG_AW-1:0] evt_addr,
  output logic              msg_valid,
  input  logic              msg_ready,
  output logic [MSG_DW-1:0] msg_data,
  output logic [MSG_AW-1:0] msg_addr
);
  localparam logic [REG_AW-1:0] CTRL_A = CTRL_OFF[REG_AW-1:0];
  localparam logic [REG_AW-1:0] STAT_A = STAT_OFF[REG_AW-1:0];

  // named internal events
  logic ctrl_wr, stat_clr, evt, stat_q, new_cond, sw_drop;
  logic mask_q, pend_q, issue, accept;
  logic unused_wbits;

  assign unused_wbits = ^reg_wdata[30:1];
  assign ctrl_wr  = qi_supported & reg_we & (reg_addr == CTRL_A);
  assign stat_clr = qi_supported & reg_we & (reg_addr == STAT_A) & reg_wdata[STAT_BIT];
  assign evt      = qi_supported & cmpl_valid & cmpl_irq;

  inv_status_flag u_stat (
    .clk(clk), .rst_n(rst_n), .evt(evt), .clr(stat_clr),
    .stat_q(stat_q), .new_cond(new_cond), .sw_drop(sw_drop)
  );

  inv_pend_ctl u_pend (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_wr), .mask_wbit(reg_wdata[MASK_BIT]),
    .new_cond(new_cond), .sw_drop(sw_drop), .accept(accept), .hold(hold),
    .busy(msg_valid), .mask_q(mask_q), .pend_q(pend_q), .issue(issue)
  );

  inv_msg_port #(.DW(MSG_DW), .AW(MSG_AW)) u_msg (
    .clk(clk), .rst_n(rst_n), .issue(issue), .evt_data(evt_data), .evt_addr(evt_addr),
    .msg_ready(msg_ready), .msg_valid(msg_valid), .msg_data(msg_data),
    .msg_addr(msg_addr), .accept(accept)
  );

  always_comb begin
    reg_rdata = '0;
    if (qi_supported) begin
      if (reg_addr == CTRL_A) begin
        reg_rdata[MASK_BIT] = mask_q;
        reg_rdata[PEND_BIT] = pend_q;
      end else if (reg_addr == STAT_A) begin
        reg_rdata[STAT_BIT] = stat_q;
      end
    end
  end

  // R3: a request only rises after a cycle with the mask clear
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msg_valid) |-> !$past(mask_q));
  // R11: without the strap the mask cannot be written
  p_unsup_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !qi_supported |=> $stable(mask_q));
  // R4: a new condition leaves flag and pending both set
  p_cond_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
    new_cond |=> (stat_q && pend_q));
endmodule

// File: tb/tb_inv_irq_ctrl.sv
module tb_inv_irq_ctrl;
  localparam int CLK_P = 10;
  localparam int DW = 16, AW = 40, RAW = 3, CA = 2, SA = 5;

  logic clk = 0, rst_n = 0, qi = 1, we = 0, cv = 0, ci = 0, hold = 0, rdy = 0;
  logic [RAW-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [DW-1:0] edata = '0, mdata;
  logic [AW-1:0] eaddr = '0, maddr;
  logic mvalid;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  inv_irq_ctrl #(.MSG_DW(DW), .MSG_AW(AW), .REG_AW(RAW), .CTRL_OFF(CA), .STAT_OFF(SA)) dut (
    .clk(clk), .rst_n(rst_n), .qi_supported(qi), .reg_we(we), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .cmpl_valid(cv), .cmpl_irq(ci), .hold(hold),
    .evt_data(edata), .evt_addr(eaddr), .msg_valid(mvalid), .msg_ready(rdy),
    .msg_data(mdata), .msg_addr(maddr)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int a, output logic [31:0] v);
    @(negedge clk); addr = a[RAW-1:0]; #1 v = rdata;
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk); addr = a[RAW-1:0]; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic complete(input logic irq);
    @(negedge clk); cv = 1; ci = irq;
    @(negedge clk); cv = 0; ci = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(CA, v); chk("R1 ctrl", v, 32'h8000_0000);
    rd(SA, v); chk("R1 stat", v, 0);
    chk("R1 valid", mvalid, 0);
  endtask

  task automatic t_ctrl_bits;
    logic [31:0] v;
    wr(CA, 32'h7FFF_FFFF); rd(CA, v); chk("R2 reserved/pending ignored", v, 0);
    wr(CA, 32'h8000_0000); rd(CA, v); chk("R2 mask rw", v, 32'h8000_0000);
  endtask

  task automatic t_masked_then_send;
    logic [31:0] v;
    complete(0); rd(SA, v); chk("R4 unqualified ignored", v, 0);
    complete(1);
    rd(SA, v); chk("R4 status set", v, 1);
    rd(CA, v); chk("R4 pending set", v, 32'hC000_0000);
    idle(5); chk("R3 masked no request", mvalid, 0);
    edata = 16'hBEEF; eaddr = 40'h12_3456_789A;
    wr(CA, 0);                   // mask clears at this edge
    @(negedge clk); chk("R6 request raised", mvalid, 1);
    chk("R6 data", mdata, 16'hBEEF); chk("R6 addr", maddr, 40'h12_3456_789A);
    edata = 16'h0; eaddr = '0;
    idle(3); chk("R8 valid held", mvalid, 1);
    chk("R8 data stable", mdata, 16'hBEEF); chk("R8 addr stable", maddr, 40'h12_3456_789A);
    rd(CA, v); chk("R6 pending while in flight", v, 32'h4000_0000);
    rdy = 1; @(negedge clk); rdy = 0;
    chk("R6 valid drops", mvalid, 0);
    rd(CA, v); chk("R6 pending cleared", v, 0);
    complete(1);                 // status still set
    rd(CA, v); chk("R5 no new pending", v, 0);
    idle(2); chk("R5 no request", mvalid, 0);
  endtask

  task automatic t_hold;
    logic [31:0] v;
    wr(SA, 1); rd(SA, v); chk("R9 w1c", v, 0);
    hold = 1; complete(1); idle(4);
    chk("R7 held no request", mvalid, 0);
    rd(CA, v); chk("R7 pending kept", v, 32'h4000_0000);
    hold = 0; @(negedge clk); @(negedge clk); chk("R7 request after release", mvalid, 1);
    rdy = 1; @(negedge clk); rdy = 0; chk("R6 accepted", mvalid, 0);
  endtask

  task automatic t_drop;
    logic [31:0] v;
    wr(CA, 32'h8000_0000); wr(SA, 1); complete(1);
    wr(SA, 0); rd(SA, v); chk("R9 write 0 no effect", v, 1);
    wr(SA, 1); rd(SA, v); chk("R9 status cleared", v, 0);
    rd(CA, v); chk("R9 pending dropped", v, 32'h8000_0000);
    wr(CA, 0); idle(3); chk("R9 no message after drop", mvalid, 0);
    wr(CA, 32'h8000_0000);
  endtask

  task automatic t_race;
    logic [31:0] v;
    complete(1);
    @(negedge clk); addr = SA[RAW-1:0]; wdata = 1; we = 1; cv = 1; ci = 1;
    @(negedge clk); we = 0; cv = 0; ci = 0;
    rd(SA, v); chk("R10 status set", v, 1);
    rd(CA, v); chk("R10 pending set", v, 32'hC000_0000);
    wr(SA, 1);
  endtask

  task automatic t_unsup;
    logic [31:0] v;
    qi = 0;
    rd(CA, v); chk("R11 ctrl reads zero", v, 0);
    rd(SA, v); chk("R11 stat reads zero", v, 0);
    wr(CA, 0); complete(1);
    qi = 1;
    rd(CA, v); chk("R11 write ignored", v, 32'h8000_0000);
    rd(SA, v); chk("R11 completion ignored", v, 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1;
    t_reset(); t_ctrl_bits(); t_masked_then_send(); t_hold(); t_drop(); t_race(); t_unsup();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule